// File: doc/BRIEF.md
# Network Controller Indirect Status and Control Registers

This block is the host-visible register file of a network controller. The host reaches it through two bus locations. One is a small pointer register that chooses one of four internal words. The other is a data port that reads or writes whichever word the pointer currently names. The pointer is sticky: it keeps its value until the host writes it again, so repeated accesses to the same word need only one pointer write.

Word 0 is the status and command word. It holds:
- command bits that are set by writing a one;
- a run state that the datapath follows;
- seven event flags that the datapath raises with one-cycle pulses and the host clears by writing a one;
- two derived summary bits;
- an interrupt enable.

Words 1 to 3 hold the initialization-block address and the bus option bits. They can be read or written only while the controller is stopped. An interrupt line is asserted whenever a flag is pending and interrupts are enabled.

Top module: `netctl_csr_block`

## Requirements
- R1: After reset, the pointer reads 0, word 0 reads 0x0004 (only the stop bit set), words 1 to 3 read 0, `irq` is low and the `cmd_*` outputs are low.
- R2: A write with `bus_sel`=1 stores `bus_wdata[1:0]` as the pointer. A read with `bus_sel`=1 returns the pointer, zero-extended. Data-port accesses (`bus_sel`=0) never change the pointer.
- R3: While the stop bit (word 0 bit 2) is clear, data-port writes to words 1 to 3 are dropped, and data-port reads of words 1 to 3 return 0. Word 0 is always accessible.
- R4: Word 0 bits 14:8 are event flags, in this order from bit 8 upward: init done, transmit done, receive done, memory error, missed frame, collision-test error, babble. Writing a one to a flag bit clears it. Writing a zero leaves it unchanged.
- R5: An event pulse sets its flag on the next cycle. If that flag is also being cleared by a write, or cleared by a stop, in the same cycle, the flag is still set.
- R6: Writing a one to bit 0 (init), bit 1 (start) or bit 3 (transmit demand) sets that bit; writing a zero does not clear it. A start also sets bit 4 (transmitter on) and bit 5 (receiver on). A start or an init clears the stop bit. `cmd_init`, `cmd_start` and `cmd_tdmd` follow bits 0, 1 and 3.
- R7: Writing a one to bit 2 sets the stop bit. In the same cycle it clears bits 0, 1, 3, 4, 5 and 6 and every flag not pulsed in that cycle. Stop wins over start and init written together with it. Words 1 to 3 keep their values.
- R8: Bits 4, 5, 7 and 15 of word 0 are read-only: writing ones to them has no effect.
- R9: Bit 7 reads as the OR of flags 14:8. Bit 15 reads as the OR of flags 14:11.
- R10: Bit 6 (interrupt enable) takes the written value on every word 0 write without stop. `irq` is high exactly when bit 6 and bit 7 are both set.
- R11: Word 1 stores bits 15:1, and its bit 0 always reads 0. Word 2 stores all 16 bits. Word 3 stores bits 2:0, and its other bits read 0. `cfg_iblk_addr` is {word 2 bits 7:0, word 1}, and `cfg_bus_opt` is word 3 bits 2:0.
- R12: A `tdmd_ack` pulse clears bit 3. A word 0 write setting bit 3 in the same cycle wins over the pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_sel | input | 1 | 1 = pointer location, 0 = data port |
| bus_wr | input | 1 | Write strobe for the selected location |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data of the selected location (combinational) |
| ev_init_done | input | 1 | Pulse: initialization finished |
| ev_tx_done | input | 1 | Pulse: transmit completed |
| ev_rx_done | input | 1 | Pulse: receive completed |
| ev_mem_err | input | 1 | Pulse: memory access error |
| ev_no_rxbuf | input | 1 | Pulse: frame missed, no buffer |
| ev_sqe_err | input | 1 | Pulse: collision-test error |
| ev_babble | input | 1 | Pulse: transmit frame too long |
| tdmd_ack | input | 1 | Pulse: datapath took the transmit demand |
| irq | output | 1 | Interrupt request |
| cmd_init | output | 1 | Init command level |
| cmd_start | output | 1 | Start command level |
| cmd_tdmd | output | 1 | Transmit demand level |
| cfg_iblk_addr | output | 24 | Initialization-block address |
| cfg_bus_opt | output | 3 | Bus option bits |

## Verification
The embedded properties watch, on every cycle, the following:
- the pointer stays put across data-port traffic;
- the address and option words stay frozen while running;
- a pulsed flag is always set one cycle later, and a flag holds while no write arrives;
- a stop always lands in the stopped state;
- a transmit-demand acknowledge clears the demand.

The exact word 0 encodings need the bench's scenarios to show them. These cover a sweep of all 128 flag-clear masks with the derived summary bits and interrupt, the per-flag error summary, read-only bits and zero writes, stop priority over simultaneous start and init, and locked reads returning zero.

// File: rtl/netctl_csr_pkg.sv
// Package: shared constants and types of the controller register block.
// Assumes a 16-bit host word and four indirectly selected registers.
package netctl_csr_pkg;
    localparam int CSR_W    = 16;
    localparam int PTR_W    = 2;
    localparam int NUM_CSR  = 1 << PTR_W;
    localparam int FLAG_N   = 7;
    localparam int FLAG_LSB = 8;
    localparam int ERR_LO   = 3;   // first error flag within the flag vector

    localparam int B_INIT = 0;
    localparam int B_STRT = 1;
    localparam int B_STOP = 2;
    localparam int B_TDMD = 3;
    localparam int B_TXON = 4;
    localparam int B_RXON = 5;
    localparam int B_INEA = 6;
    localparam int B_INTR = 7;
    localparam int B_ERR  = 15;

    typedef enum logic [PTR_W-1:0] {
        SEL_STATUS  = 2'd0,
        SEL_ADDR_LO = 2'd1,
        SEL_ADDR_HI = 2'd2,
        SEL_BUSCFG  = 2'd3
    } csr_sel_e;
endpackage

// File: rtl/netctl_csr_ptr.sv
// Module: sticky register pointer with one-hot decode.
// Assumes ptr_wr and data_acc are never high together (top derives both
// from one select line).
module netctl_csr_ptr #(
    parameter int SEL_W = 2
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    ptr_wr,
    input  logic [SEL_W-1:0]        ptr_wdata,
    input  logic                    data_acc,
    output logic [SEL_W-1:0]        sel_q,
    output logic [(1<<SEL_W)-1:0]   sel_hot
);
    localparam int SEL_N = 1 << SEL_W;

    // Purpose: hold the selection until the host rewrites it.
    always_ff @(posedge clk) begin
        if (!rst_n)      sel_q <= '0;
        else if (ptr_wr) sel_q <= ptr_wdata;
    end

    // Purpose: one decode line per selectable register.
    for (genvar g = 0; g < SEL_N; g++) begin : g_dec
        assign sel_hot[g] = (sel_q == SEL_W'(g));
    end

    p_sel_sticky_r2: assert property (@(posedge clk) disable iff (!rst_n)
        data_acc |=> $stable(sel_q));
    p_sel_onehot_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(sel_hot) == 1);
endmodule

// File: rtl/netctl_csr_status.sv
// Module: status/command word. Holds set-on-one commands, run state,
// write-one-to-clear event flags, derived summaries and the interrupt.
// Assumes wr_en is already qualified by pointer == 0 and a data write.
module netctl_csr_status
    import netctl_csr_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [CSR_W-1:0]  wdata,
    input  logic [FLAG_N-1:0] ev_flag,
    input  logic              tdmd_ack,
    output logic [CSR_W-1:0]  csr_word,
    output logic              stopped,
    output logic              cmd_init,
    output logic              cmd_start,
    output logic              cmd_tdmd,
    output logic              irq
);
    logic              init_q, strt_q, stop_q, tdmd_q, txon_q, rxon_q, inea_q;
    logic [FLAG_N-1:0] flag_q;
    logic              stop_hit, start_hit, init_hit, tdmd_hit;
    logic              intr, err;
    logic              unused_wbits;

    assign unused_wbits = ^{wdata[B_ERR], wdata[B_INTR], wdata[B_RXON], wdata[B_TXON]};

    // Purpose: decode command writes with stop taking priority.
    always_comb begin
        stop_hit  = wr_en & wdata[B_STOP];
        start_hit = wr_en & wdata[B_STRT] & ~stop_hit;
        init_hit  = wr_en & wdata[B_INIT] & ~stop_hit;
        tdmd_hit  = wr_en & wdata[B_TDMD] & ~stop_hit;
    end

    // Purpose: run state, command bits and interrupt enable.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stop_q <= 1'b1;
            init_q <= 1'b0; strt_q <= 1'b0; tdmd_q <= 1'b0;
            txon_q <= 1'b0; rxon_q <= 1'b0; inea_q <= 1'b0;
        end else if (stop_hit) begin
            stop_q <= 1'b1;
            init_q <= 1'b0; strt_q <= 1'b0; tdmd_q <= 1'b0;
            txon_q <= 1'b0; rxon_q <= 1'b0; inea_q <= 1'b0;
        end else begin
            if (start_hit || init_hit) stop_q <= 1'b0;
            if (init_hit) init_q <= 1'b1;
            if (start_hit) begin
                strt_q <= 1'b1;
                txon_q <= 1'b1;
                rxon_q <= 1'b1;
            end
            if (tdmd_hit)      tdmd_q <= 1'b1;
            else if (tdmd_ack) tdmd_q <= 1'b0;
            if (wr_en) inea_q <= wdata[B_INEA];
        end
    end

    // Purpose: one event flag per slice; a pulse beats any clear.
    for (genvar i = 0; i < FLAG_N; i++) begin : g_flag
        logic clr_hit;
        assign clr_hit = wr_en & wdata[FLAG_LSB + i];

        always_ff @(posedge clk) begin
            if (!rst_n) flag_q[i] <= 1'b0;
            else        flag_q[i] <= ev_flag[i] | (flag_q[i] & ~clr_hit & ~stop_hit);
        end

        p_event_wins_r5: assert property (@(posedge clk) disable iff (!rst_n)
            ev_flag[i] |=> flag_q[i]);
        p_flag_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
            (flag_q[i] && !wr_en) |=> flag_q[i]);
    end

    // Purpose: summaries and the assembled readable word.
    always_comb begin
        intr = |flag_q;
        err  = |flag_q[FLAG_N-1:ERR_LO];
        csr_word = '0;
        csr_word[B_INIT] = init_q;
        csr_word[B_STRT] = strt_q;
        csr_word[B_STOP] = stop_q;
        csr_word[B_TDMD] = tdmd_q;
        csr_word[B_TXON] = txon_q;
        csr_word[B_RXON] = rxon_q;
        csr_word[B_INEA] = inea_q;
        csr_word[B_INTR] = intr;
        csr_word[FLAG_LSB +: FLAG_N] = flag_q;
        csr_word[B_ERR]  = err;
    end

    assign stopped   = stop_q;
    assign cmd_init  = init_q;
    assign cmd_start = strt_q;
    assign cmd_tdmd  = tdmd_q;
    assign irq       = intr & inea_q;

    p_stop_priority_r7: assert property (@(posedge clk) disable iff (!rst_n)
        stop_hit |=> (stop_q && !strt_q && !init_q && !txon_q && !rxon_q && !inea_q));
    p_start_runs_r6: assert property (@(posedge clk) disable iff (!rst_n)
        start_hit |=> (!stop_q && txon_q && rxon_q));
    p_tdmd_ack_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (tdmd_ack && !tdmd_hit) |=> !tdmd_q);
    p_irq_needs_en_r10: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (inea_q && (flag_q != '0)));
endmodule

// File: rtl/netctl_csr_cfg.sv
// Module: configuration words (init-block address low/high, bus options).
// Assumes the caller marks which config word is selected; writes are
// accepted only while the controller is stopped.
module netctl_csr_cfg
    import netctl_csr_pkg::*;
#(
    parameter int HI_ADDR_W = 8,
    parameter int BUS_OPT_W = 3
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          wr_en,
    input  logic [NUM_CSR-2:0]            sel_cfg,
    input  logic [CSR_W-1:0]              wdata,
    input  logic                          stopped,
    output logic [CSR_W-1:0]              csr1_word,
    output logic [CSR_W-1:0]              csr2_word,
    output logic [CSR_W-1:0]              csr3_word,
    output logic [HI_ADDR_W+CSR_W-1:0]    iblk_addr,
    output logic [BUS_OPT_W-1:0]          bus_opt
);
    localparam int LO_W  = CSR_W - 1;
    localparam int RSV_W = CSR_W - HI_ADDR_W;

    logic [LO_W-1:0]      lo_q;
    logic [HI_ADDR_W-1:0] hi_q;
    logic [RSV_W-1:0]     rsv_q;
    logic [BUS_OPT_W-1:0] opt_q;
    logic                 wr_ok;

    assign wr_ok = wr_en & stopped;

    // Purpose: the three lockable configuration words.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lo_q  <= '0;
            hi_q  <= '0;
            rsv_q <= '0;
            opt_q <= '0;
        end else if (wr_ok) begin
            if (sel_cfg[0]) lo_q <= wdata[CSR_W-1:1];
            if (sel_cfg[1]) {rsv_q, hi_q} <= wdata;
            if (sel_cfg[2]) opt_q <= wdata[BUS_OPT_W-1:0];
        end
    end

    assign csr1_word = {lo_q, 1'b0};
    assign csr2_word = {rsv_q, hi_q};
    assign csr3_word = {(CSR_W-BUS_OPT_W)'(0), opt_q};
    assign iblk_addr = {hi_q, lo_q, 1'b0};
    assign bus_opt   = opt_q;

    p_locked_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !stopped |=> $stable({lo_q, hi_q, rsv_q, opt_q}));
    p_lo_write_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_ok && sel_cfg[0]) |=> (lo_q == $past(wdata[CSR_W-1:1])));
endmodule

// File: rtl/netctl_csr_block.sv
// Module: top of the indirect register block. Splits the host bus into
// pointer and data-port accesses and selects the read word.
// Assumes single-cycle write strobes; reads have no side effects.
module netctl_csr_block
    import netctl_csr_pkg::*;
#(
    parameter int HI_ADDR_W = 8,
    parameter int BUS_OPT_W = 3
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        bus_sel,
    input  logic                        bus_wr,
    input  logic [15:0]                 bus_wdata,
    output logic [15:0]                 bus_rdata,
    input  logic                        ev_init_done,
    input  logic                        ev_tx_done,
    input  logic                        ev_rx_done,
    input  logic                        ev_mem_err,
    input  logic                        ev_no_rxbuf,
    input  logic                        ev_sqe_err,
    input  logic                        ev_babble,
    input  logic                        tdmd_ack,
    output logic                        irq,
    output logic                        cmd_init,
    output logic                        cmd_start,
    output logic                        cmd_tdmd,
    output logic [HI_ADDR_W+15:0]       cfg_iblk_addr,
    output logic [BUS_OPT_W-1:0]        cfg_bus_opt
);
    logic [PTR_W-1:0]   sel_q;
    logic [NUM_CSR-1:0] sel_hot;
    csr_sel_e           sel_e;
    logic               ptr_wr, data_wr;
    logic               stopped;
    logic [CSR_W-1:0]   csr0_word, csr1_word, csr2_word, csr3_word, data_word;
    logic [FLAG_N-1:0]  ev_flag;

    assign ptr_wr  = bus_wr & bus_sel;
    assign data_wr = bus_wr & ~bus_sel;
    assign sel_e   = csr_sel_e'(sel_q);
    assign ev_flag = {ev_babble, ev_sqe_err, ev_no_rxbuf, ev_mem_err,
                      ev_rx_done, ev_tx_done, ev_init_done};

    netctl_csr_ptr #(.SEL_W(PTR_W)) u_ptr (
        .clk       (clk),
        .rst_n     (rst_n),
        .ptr_wr    (ptr_wr),
        .ptr_wdata (bus_wdata[PTR_W-1:0]),
        .data_acc  (data_wr),
        .sel_q     (sel_q),
        .sel_hot   (sel_hot)
    );

    netctl_csr_status u_status (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (data_wr & sel_hot[SEL_STATUS]),
        .wdata     (bus_wdata),
        .ev_flag   (ev_flag),
        .tdmd_ack  (tdmd_ack),
        .csr_word  (csr0_word),
        .stopped   (stopped),
        .cmd_init  (cmd_init),
        .cmd_start (cmd_start),
        .cmd_tdmd  (cmd_tdmd),
        .irq       (irq)
    );

    netctl_csr_cfg #(.HI_ADDR_W(HI_ADDR_W), .BUS_OPT_W(BUS_OPT_W)) u_cfg (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (data_wr),
        .sel_cfg   (sel_hot[NUM_CSR-1:1]),
        .wdata     (bus_wdata),
        .stopped   (stopped),
        .csr1_word (csr1_word),
        .csr2_word (csr2_word),
        .csr3_word (csr3_word),
        .iblk_addr (cfg_iblk_addr),
        .bus_opt   (cfg_bus_opt)
    );

    // Purpose: pick the read word; locked words read as zero.
    always_comb begin
        data_word = '0;
        case (sel_e)
            SEL_STATUS:  data_word = csr0_word;
            SEL_ADDR_LO: if (stopped) data_word = csr1_word;
            SEL_ADDR_HI: if (stopped) data_word = csr2_word;
            SEL_BUSCFG:  if (stopped) data_word = csr3_word;
            default:     data_word = '0;
        endcase
        bus_rdata = bus_sel ? CSR_W'(sel_q) : data_word;
    end

    p_locked_read_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!bus_sel && !stopped && sel_e != SEL_STATUS) |-> (bus_rdata == '0));
endmodule

// File: tb/netctl_csr_block_test.sv
`timescale 1ns/1ps
module netctl_csr_block_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_sel = 1'b0;
    logic        bus_wr = 1'b0;
    logic [15:0] bus_wdata = '0;
    logic [15:0] bus_rdata;
    logic [6:0]  ev = '0;
    logic        tdmd_ack = 1'b0;
    logic        irq, cmd_init, cmd_start, cmd_tdmd;
    logic [23:0] cfg_iblk_addr;
    logic [2:0]  cfg_bus_opt;

    int total = 0;
    int bad = 0;
    bit finished = 0;

    always #2.5 clk = ~clk;

    netctl_csr_block uut (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .ev_init_done(ev[0]), .ev_tx_done(ev[1]), .ev_rx_done(ev[2]),
        .ev_mem_err(ev[3]), .ev_no_rxbuf(ev[4]), .ev_sqe_err(ev[5]),
        .ev_babble(ev[6]), .tdmd_ack(tdmd_ack), .irq(irq),
        .cmd_init(cmd_init), .cmd_start(cmd_start), .cmd_tdmd(cmd_tdmd),
        .cfg_iblk_addr(cfg_iblk_addr), .cfg_bus_opt(cfg_bus_opt)
    );

    // Expected word 0 from low control bits (INEA..INIT) and flags.
    function automatic logic [15:0] ex0(input logic [6:0] ctl, input logic [6:0] fl);
        return {|fl[6:3], fl, |fl, ctl};
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic sel, input logic [15:0] d,
                      input logic [6:0] e = 7'h0, input logic ack = 1'b0);
        @(negedge clk);
        bus_sel = sel; bus_wr = 1'b1; bus_wdata = d; ev = e; tdmd_ack = ack;
        @(negedge clk);
        bus_wr = 1'b0; ev = '0; tdmd_ack = 1'b0;
    endtask

    task automatic pulse(input logic [6:0] e, input logic ack = 1'b0);
        @(negedge clk);
        ev = e; tdmd_ack = ack;
        @(negedge clk);
        ev = '0; tdmd_ack = 1'b0;
    endtask

    task automatic rd(input logic sel, output logic [15:0] d);
        bus_sel = sel;
        #1;
        d = bus_rdata;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            total++; bad++;
            $display("FAIL watchdog: actual=running expected=done");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [15:0] r;
        logic [15:0] lo_last, hi_last;
        logic [2:0]  opt_last;
        logic [6:0]  fl;
        lo_last = '0; hi_last = '0; opt_last = '0;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        rd(1'b1, r); check("R1 ptr", r, 0);
        rd(1'b0, r); check("R1 csr0", r, 16'h0004);
        check("R1 irq", irq, 0);
        check("R1 cmds", {cmd_init, cmd_start, cmd_tdmd}, 0);
        for (int p = 1; p < 4; p++) begin
            wr(1'b1, 16'(p));
            rd(1'b0, r); check("R1 cfg word", r, 0);
        end

        // R2 pointer persists across data accesses
        for (int p = 0; p < 4; p++) begin
            wr(1'b1, 16'hFFFC | 16'(p));
            rd(1'b1, r); check("R2 ptr write", r, 16'(p));
            wr(1'b0, 16'h0000);
            wr(1'b0, 16'h0000);
            rd(1'b1, r); check("R2 ptr sticky", r, 16'(p));
        end

        // R11 configuration layouts while stopped
        wr(1'b1, 16'd1);
        for (int k = 0; k < 16; k++) begin
            logic [15:0] v;
            v = 16'(k * 16'h1357 + 1);
            wr(1'b0, v);
            rd(1'b0, r); check("R11 word1", r, v & 16'hFFFE);
            lo_last = v & 16'hFFFE;
        end
        wr(1'b1, 16'd2);
        for (int k = 0; k < 16; k++) begin
            logic [15:0] v;
            v = 16'(k * 16'h2469 + 3);
            wr(1'b0, v);
            rd(1'b0, r); check("R11 word2", r, v);
            hi_last = v;
        end
        check("R11 iblk addr", cfg_iblk_addr, {hi_last[7:0], lo_last});
        wr(1'b1, 16'd3);
        for (int k = 0; k < 16; k++) begin
            logic [15:0] v;
            v = {12'(k * 37), 4'(k)};
            wr(1'b0, v);
            rd(1'b0, r); check("R11 word3", r, {13'b0, v[2:0]});
            check("R11 bus opt", cfg_bus_opt, v[2:0]);
            opt_last = v[2:0];
        end

        // R6 start
        wr(1'b1, 16'd0);
        wr(1'b0, 16'h0002);
        rd(1'b0, r); check("R6 start", r, ex0(7'h32, 0));
        check("R6 cmd_start", cmd_start, 1);

        // R3 locked while running
        for (int p = 1; p < 4; p++) begin
            wr(1'b1, 16'(p));
            wr(1'b0, 16'hFFFF);
            rd(1'b0, r); check("R3 locked read", r, 0);
        end
        check("R3 addr kept", cfg_iblk_addr, {hi_last[7:0], lo_last});
        check("R3 opt kept", cfg_bus_opt, opt_last);
        wr(1'b1, 16'd0);

        // R6 zero write changes nothing
        wr(1'b0, 16'h0000);
        rd(1'b0, r); check("R6 zero write", r, ex0(7'h32, 0));

        // R12 transmit demand
        wr(1'b0, 16'h0008);
        rd(1'b0, r); check("R6 tdmd set", r, ex0(7'h3A, 0));
        check("R12 cmd_tdmd", cmd_tdmd, 1);
        pulse(7'h0, 1'b1);
        rd(1'b0, r); check("R12 ack clears", r, ex0(7'h32, 0));
        wr(1'b0, 16'h0008, 7'h0, 1'b1);
        rd(1'b0, r); check("R12 write wins", r, ex0(7'h3A, 0));
        pulse(7'h0, 1'b1);

        // R6 init
        wr(1'b0, 16'h0001);
        rd(1'b0, r); check("R6 init", r, ex0(7'h33, 0));
        check("R6 cmd_init", cmd_init, 1);

        // R9/R10 all flags, enable off then on
        pulse(7'h7F);
        rd(1'b0, r); check("R9 all flags", r, ex0(7'h33, 7'h7F));
        check("R10 irq masked", irq, 0);
        wr(1'b0, 16'h0040);
        rd(1'b0, r); check("R10 enable", r, ex0(7'h73, 7'h7F));
        check("R10 irq on", irq, 1);

        // R4 sweep of every clear mask
        for (int m = 0; m < 128; m++) begin
            pulse(7'h7F);
            wr(1'b0, {1'b0, 7'(m), 8'h40});
            fl = ~7'(m);
            rd(1'b0, r); check("R4 clear mask", r, ex0(7'h73, fl));
            check("R10 irq sweep", irq, fl != 0);
        end

        // R5 event beats clear
        wr(1'b0, 16'h7F40, 7'h7F);
        rd(1'b0, r); check("R5 event wins", r, ex0(7'h73, 7'h7F));

        // R9 per-flag summaries
        for (int i = 0; i < 7; i++) begin
            wr(1'b0, 16'h7F40);
            pulse(7'(1 << i));
            rd(1'b0, r); check("R9 single flag", r, ex0(7'h73, 7'(1 << i)));
        end
        wr(1'b0, 16'h7F40);

        // R8 read-only bits while running
        wr(1'b0, 16'h80F0);
        rd(1'b0, r); check("R8 ro running", r, ex0(7'h73, 0));
        check("R8 irq", irq, 0);

        // R7 stop beats start and init
        pulse(7'h04);
        check("R10 irq rx", irq, 1);
        wr(1'b0, 16'h0007);
        rd(1'b0, r); check("R7 stop", r, 16'h0004);
        check("R7 irq", irq, 0);
        check("R7 cmds", {cmd_init, cmd_start, cmd_tdmd}, 0);
        wr(1'b1, 16'd1);
        rd(1'b0, r); check("R7 cfg kept", r, lo_last);
        wr(1'b1, 16'd0);
        wr(1'b0, 16'h0004, 7'h40);
        rd(1'b0, r); check("R5 event beats stop", r, ex0(7'h04, 7'h40));
        wr(1'b0, 16'h4000);
        rd(1'b0, r); check("R4 clear babble", r, 16'h0004);

        // R8 read-only bits while stopped
        wr(1'b0, 16'h00B0);
        rd(1'b0, r); check("R8 ro stopped", r, 16'h0004);

        // R6 init leaves stopped state
        wr(1'b0, 16'h0001);
        rd(1'b0, r); check("R6 init clears stop", r, ex0(7'h01, 0));

        finished = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule